// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits behind a 32-bit host write path and turns streams of single-dword writes into atomic updates of 128-bit control registers and 64-bit memory words. Dwords addressed to a wide target are gathered in one shared collector. The full word is handed to the register file or memory only when every dword of it has arrived. A write to a narrow register bypasses the collector and goes straight out on its own port.

Two 128-bit descriptor-pointer registers in every per-queue page use a relaxed rule, so that software can update them without a lock. A write to their top dword always commits the register at once. Any lower dwords that have not been gathered are sent as zero. A lower-dword write to such a register is thrown away when the collector is busy with another register. A narrow write to the timer command register in page 0 also empties the collector.

The byte address has three fields. The top bit selects the memory window. The next bits give the page number. The low `PAGE_SHIFT` bits give the offset within the page, so pages repeat every 0x2000 bytes. The write port uses a valid/ready handshake. `wr_ready` is always high, so a dword is taken on every clock edge where `wr_valid` is high and there is no back-pressure. The commit ports are one-cycle strobes with no ready: the register file, memory and narrow registers must take each strobe when it occurs.

Top module: `wide_write_collector`

## Requirements
- R1: After reset no commit strobe is high and the collector is empty. As a result, a lone top-dword descriptor write commits with its low 96 bits zero.
- R2: A 128-bit register (register space, not a descriptor or narrow offset) commits once all four dwords (dword index = addr[3:2]) have been written, in any order. The commit appears on the register port in the cycle after the fourth write is accepted. Dword n fills bits 32n+31:32n, and the commit address is 16-byte aligned.
- R3: An address with addr[19]=1 selects a 64-bit memory word (dword index = addr[2]). It commits on the memory port, 8-byte aligned, in the cycle after both dwords have been written.
- R4: A wide or memory write to a different aligned word than the one held drops the held partial data and starts over with only the new dword.
- R5: Offsets 0x830 and 0xA10 are descriptor registers in every page. A write to the top dword (+12) commits that register in the next cycle. The commit carries the gathered dwords 0 to 2 when all three are held for the same register.
- R6: If a top-dword descriptor commit finds any of dwords 0 to 2 missing for that register, bits 95:0 of the commit are zero.
- R7: A descriptor lower-dword write is discarded while the collector holds a different word. The held contents stay unchanged.
- R8: A narrow write to offset 0x420 in page 0 empties the collector and is also committed on the narrow port. The same offset in any other page leaves the collector intact.
- R9: Offsets 0x400 to 0x4FF in register space are narrow registers. They commit on the narrow port in the next cycle without touching the collector.
- R10: Every commit strobe lasts one cycle, at most one port commits per cycle, and the collector is empty after any commit.
- R11: `wr_ready` stays high, back-to-back dwords are taken every cycle, and addr[1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host dword write valid |
| wr_ready | output | 1 | Always high; a write is taken when valid |
| wr_addr | input | 20 | Byte address of the dword |
| wr_data | input | 32 | Dword data |
| reg_cmt_valid | output | 1 | 128-bit register commit strobe |
| reg_cmt_addr | output | 20 | 16-byte aligned register address |
| reg_cmt_data | output | 128 | Register word |
| mem_cmt_valid | output | 1 | 64-bit memory commit strobe |
| mem_cmt_addr | output | 20 | 8-byte aligned memory address |
| mem_cmt_data | output | 64 | Memory word |
| dir_cmt_valid | output | 1 | Narrow register commit strobe |
| dir_cmt_addr | output | 20 | 4-byte aligned narrow register address |
| dir_cmt_data | output | 32 | Narrow register data |

## Verification
The bench writes wide registers with their dwords in shuffled order. Correct data then shows that each dword lands by its address and not by arrival order. Interleaved writes to another wide word, a narrow register or a timer command separate the replace, bypass and clear rules, because each of them changes whether a later dword completes a commit. Descriptor writes are tried with a full set of lower dwords, a partial set and an empty collector, which separates full commits from zero-filled ones. A lower descriptor write aimed at a busy collector, followed by completion of the held register, shows whether the discard left the held data intact.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
  localparam int DWORD_W = 32;
  localparam int WIDE_W  = 128;
  localparam int MEM_W   = 64;
  localparam int WIDE_DWORDS = WIDE_W / DWORD_W;

  typedef enum logic [1:0] {
    ACC_NARROW = 2'd0,
    ACC_MEM    = 2'd1,
    ACC_WIDE   = 2'd2,
    ACC_DESC   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
  import wwc_pkg::*;
#(
  parameter int AW = 20,
  parameter int PAGE_SHIFT = 13,
  parameter logic [PAGE_SHIFT-1:0] DESC_OFF_A = 13'h830,
  parameter logic [PAGE_SHIFT-1:0] DESC_OFF_B = 13'hA10,
  parameter logic [PAGE_SHIFT-1:0] TIMER_OFF  = 13'h420,
  parameter logic [PAGE_SHIFT-1:0] NARROW_OFF = 13'h400
) (
  input  logic [AW-1:0] addr,
  output acc_kind_e     kind,
  output logic [1:0]    idx,
  output logic [AW-1:0] base,
  output logic          timer_clr
);
  localparam int PAGE_W = AW - 1 - PAGE_SHIFT;

  logic                  in_mem;
  logic [PAGE_SHIFT-1:0] off;
  logic [PAGE_SHIFT-1:0] off_wide;
  logic [PAGE_SHIFT-1:0] off_dw;
  logic [PAGE_W-1:0]     page;
  logic [1:0]            unused_low;

  assign in_mem     = addr[AW-1];
  assign off        = addr[PAGE_SHIFT-1:0];
  assign page       = addr[AW-2:PAGE_SHIFT];
  assign off_wide   = {off[PAGE_SHIFT-1:4], 4'b0000};
  assign off_dw     = {off[PAGE_SHIFT-1:2], 2'b00};
  assign unused_low = addr[1:0];

  always_comb begin
    kind      = ACC_WIDE;
    idx       = addr[3:2];
    base      = {addr[AW-1:4], 4'b0000};
    timer_clr = 1'b0;
    if (in_mem) begin
      kind = ACC_MEM;
      idx  = {1'b0, addr[2]};
      base = {addr[AW-1:3], 3'b000};
    end else if (off_wide == DESC_OFF_A || off_wide == DESC_OFF_B) begin
      kind = ACC_DESC;
    end else if (off[PAGE_SHIFT-1:8] == NARROW_OFF[PAGE_SHIFT-1:8]) begin
      kind      = ACC_NARROW;
      idx       = 2'd0;
      base      = {addr[AW-1:2], 2'b00};
      timer_clr = (page == '0) && (off_dw == TIMER_OFF);
    end
  end
endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
  import wwc_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc,
  input  acc_kind_e            kind,
  input  logic [1:0]           idx,
  input  logic [AW-1:0]        base,
  input  logic [DWORD_W-1:0]   data,
  input  logic                 timer_clr,
  output logic                 cmt_wide,
  output logic                 cmt_mem,
  output logic [WIDE_W-1:0]    cmt_word
);
  logic [WIDE_DWORDS-1:0] c_mask;
  logic [AW-1:0]          c_base;
  logic                   c_mem;
  logic [WIDE_W-1:0]      c_data;

  logic                   is_mem;
  logic                   hit;
  logic [WIDE_DWORDS-1:0] held_mask;
  logic [WIDE_W-1:0]      held_data;
  logic [WIDE_DWORDS-1:0] m_mask;
  logic [WIDE_W-1:0]      m_data;
  logic                   full;
  logic                   desc_last;
  logic                   desc_drop;
  logic                   desc_full;

  assign is_mem    = (kind == ACC_MEM);
  assign hit       = (c_mask != '0) && (c_base == base) && (c_mem == is_mem);
  assign held_mask = hit ? c_mask : '0;
  assign held_data = hit ? c_data : '0;
  assign m_mask    = held_mask | (WIDE_DWORDS'(1) << idx);

  for (genvar g = 0; g < WIDE_DWORDS; g++) begin : g_lane
    assign m_data[g*DWORD_W +: DWORD_W] =
      (idx == 2'(g)) ? data : held_data[g*DWORD_W +: DWORD_W];
  end

  assign full      = is_mem ? (&m_mask[1:0]) : (&m_mask);
  assign desc_last = (kind == ACC_DESC) && (idx == 2'd3);
  assign desc_drop = (kind == ACC_DESC) && (idx != 2'd3) && (c_mask != '0) && !hit;
  assign desc_full = hit && (&c_mask[2:0]);

  assign cmt_wide = acc && (((kind == ACC_WIDE) && full) || desc_last);
  assign cmt_mem  = acc && is_mem && full;

  always_comb begin
    if (desc_last)
      cmt_word = {data, (desc_full ? c_data[95:0] : 96'b0)};
    else if (is_mem)
      cmt_word = {{(WIDE_W-MEM_W){1'b0}}, m_data[MEM_W-1:0]};
    else
      cmt_word = m_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_mask <= '0;
      c_base <= '0;
      c_mem  <= 1'b0;
      c_data <= '0;
    end else if (acc) begin
      if (kind == ACC_NARROW) begin
        if (timer_clr) c_mask <= '0;
      end else if (cmt_wide || cmt_mem) begin
        c_mask <= '0;
      end else if (!desc_drop) begin
        c_mask <= m_mask;
        c_base <= base;
        c_mem  <= is_mem;
        c_data <= m_data;
      end
    end
  end

  assert_commit_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_wide || cmt_mem) |=> (c_mask == '0));

  assert_desc_drop_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && desc_drop) |=> ($stable(c_mask) && $stable(c_base) && $stable(c_data)));

  assert_timer_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && kind == ACC_NARROW && timer_clr) |=> (c_mask == '0));

  assert_mem_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_mem |-> (c_mask[3:2] == 2'b00));
endmodule

// File: rtl/wwc_commit_regs.sv
module wwc_commit_regs
  import wwc_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_fire,
  input  logic               mem_fire,
  input  logic               dir_fire,
  input  logic [AW-1:0]      base,
  input  logic [WIDE_W-1:0]  word,
  input  logic [DWORD_W-1:0] dir_word,
  output logic               reg_valid,
  output logic [AW-1:0]      reg_addr,
  output logic [WIDE_W-1:0]  reg_data,
  output logic               mem_valid,
  output logic [AW-1:0]      mem_addr,
  output logic [MEM_W-1:0]   mem_data,
  output logic               dir_valid,
  output logic [AW-1:0]      dir_addr,
  output logic [DWORD_W-1:0] dir_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_valid <= 1'b0;
      mem_valid <= 1'b0;
      dir_valid <= 1'b0;
      reg_addr  <= '0;
      reg_data  <= '0;
      mem_addr  <= '0;
      mem_data  <= '0;
      dir_addr  <= '0;
      dir_data  <= '0;
    end else begin
      reg_valid <= wide_fire;
      mem_valid <= mem_fire;
      dir_valid <= dir_fire;
      if (wide_fire) begin
        reg_addr <= base;
        reg_data <= word;
      end
      if (mem_fire) begin
        mem_addr <= base;
        mem_data <= word[MEM_W-1:0];
      end
      if (dir_fire) begin
        dir_addr <= base;
        dir_data <= dir_word;
      end
    end
  end

  assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_valid, mem_valid, dir_valid}));

  assert_reg_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> (reg_addr[3:0] == 4'h0));

  assert_mem_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[2:0] == 3'h0));
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import wwc_pkg::*;
#(
  parameter int AW = 20,
  parameter int PAGE_SHIFT = 13,
  parameter logic [PAGE_SHIFT-1:0] DESC_OFF_A = 13'h830,
  parameter logic [PAGE_SHIFT-1:0] DESC_OFF_B = 13'hA10,
  parameter logic [PAGE_SHIFT-1:0] TIMER_OFF  = 13'h420,
  parameter logic [PAGE_SHIFT-1:0] NARROW_OFF = 13'h400
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  output logic           reg_cmt_valid,
  output logic [AW-1:0]  reg_cmt_addr,
  output logic [127:0]   reg_cmt_data,
  output logic           mem_cmt_valid,
  output logic [AW-1:0]  mem_cmt_addr,
  output logic [63:0]    mem_cmt_data,
  output logic           dir_cmt_valid,
  output logic [AW-1:0]  dir_cmt_addr,
  output logic [31:0]    dir_cmt_data
);
  acc_kind_e          kind;
  logic [1:0]         idx;
  logic [AW-1:0]      base;
  logic               timer_clr;
  logic               acc;
  logic               cmt_wide;
  logic               cmt_mem;
  logic [WIDE_W-1:0]  cmt_word;

  assign wr_ready = 1'b1;
  assign acc      = wr_valid && wr_ready;

  wwc_decode #(
    .AW(AW), .PAGE_SHIFT(PAGE_SHIFT),
    .DESC_OFF_A(DESC_OFF_A), .DESC_OFF_B(DESC_OFF_B),
    .TIMER_OFF(TIMER_OFF), .NARROW_OFF(NARROW_OFF)
  ) u_dec (
    .addr(wr_addr), .kind(kind), .idx(idx), .base(base), .timer_clr(timer_clr)
  );

  wwc_collector #(.AW(AW)) u_col (
    .clk(clk), .rst_n(rst_n), .acc(acc), .kind(kind), .idx(idx),
    .base(base), .data(wr_data), .timer_clr(timer_clr),
    .cmt_wide(cmt_wide), .cmt_mem(cmt_mem), .cmt_word(cmt_word)
  );

  wwc_commit_regs #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .wide_fire(cmt_wide), .mem_fire(cmt_mem),
    .dir_fire(acc && kind == ACC_NARROW),
    .base(base), .word(cmt_word), .dir_word(wr_data),
    .reg_valid(reg_cmt_valid), .reg_addr(reg_cmt_addr), .reg_data(reg_cmt_data),
    .mem_valid(mem_cmt_valid), .mem_addr(mem_cmt_addr), .mem_data(mem_cmt_data),
    .dir_valid(dir_cmt_valid), .dir_addr(dir_cmt_addr), .dir_data(dir_cmt_data)
  );

  assert_desc_top_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && kind == ACC_DESC && idx == 2'd3) |=> reg_cmt_valid);

  assert_narrow_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && kind == ACC_NARROW) |=> (dir_cmt_valid && !reg_cmt_valid && !mem_cmt_valid));
endmodule

// File: tb/sim_wide_write_collector.sv
`timescale 1ns/1ps
module sim_wide_write_collector;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [19:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         reg_cmt_valid, mem_cmt_valid, dir_cmt_valid;
  logic [19:0]  reg_cmt_addr, mem_cmt_addr, dir_cmt_addr;
  logic [127:0] reg_cmt_data;
  logic [63:0]  mem_cmt_data;
  logic [31:0]  dir_cmt_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [1:0]   q_kind[$];
  logic [19:0]  q_addr[$];
  logic [127:0] q_data[$];
  string        q_tag[$];

  always #5 clk = ~clk;

  wide_write_collector u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .reg_cmt_valid(reg_cmt_valid), .reg_cmt_addr(reg_cmt_addr), .reg_cmt_data(reg_cmt_data),
    .mem_cmt_valid(mem_cmt_valid), .mem_cmt_addr(mem_cmt_addr), .mem_cmt_data(mem_cmt_data),
    .dir_cmt_valid(dir_cmt_valid), .dir_cmt_addr(dir_cmt_addr), .dir_cmt_data(dir_cmt_data)
  );

  function automatic logic [19:0] pg(input int p, input logic [12:0] o);
    return {1'b0, 6'(p), o};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input logic [1:0] k, input logic [19:0] a, input logic [127:0] d, input string tag);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  task automatic put(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: scoreboard comparison (kind 0 = register, 1 = memory, 2 = narrow)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reg_cmt_valid || mem_cmt_valid || dir_cmt_valid) begin
        logic [1:0]   k;
        logic [19:0]  a;
        logic [127:0] d;
        k = reg_cmt_valid ? 2'd0 : (mem_cmt_valid ? 2'd1 : 2'd2);
        a = reg_cmt_valid ? reg_cmt_addr : (mem_cmt_valid ? mem_cmt_addr : dir_cmt_addr);
        d = reg_cmt_valid ? reg_cmt_data : (mem_cmt_valid ? {64'b0, mem_cmt_data} : {96'b0, dir_cmt_data});
        check($countones({reg_cmt_valid, mem_cmt_valid, dir_cmt_valid}) == 1,
              "R10 single port", 128'($countones({reg_cmt_valid, mem_cmt_valid, dir_cmt_valid})), 128'd1);
        if (q_kind.size() == 0) begin
          check(1'b0, "R10 unexpected commit", {106'b0, k, a}, 128'b0);
        end else begin
          logic [1:0]   ek;
          logic [19:0]  ea;
          logic [127:0] ed;
          string        et;
          ek = q_kind.pop_front(); ea = q_addr.pop_front();
          ed = q_data.pop_front(); et = q_tag.pop_front();
          check(k == ek && a == ea, {et, " port/addr"}, {106'b0, k, a}, {106'b0, ek, ea});
          check(d == ed, {et, " data"}, d, ed);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: nothing committed after reset
    check(!reg_cmt_valid && !mem_cmt_valid && !dir_cmt_valid, "R1 idle after reset",
          {125'b0, reg_cmt_valid, mem_cmt_valid, dir_cmt_valid}, 128'b0);
    // R11: ready held high
    check(wr_ready == 1'b1, "R11 ready", {127'b0, wr_ready}, 128'd1);

    // R1/R6: empty collector, lone top dword of descriptor B page 3
    expect_item(0, pg(3, 13'hA10), {32'hD3D3_0001, 96'b0}, "R6 zero fill after reset");
    put(pg(3, 13'hA1C), 32'hD3D3_0001);
    idle();

    // R2: shuffled dword order
    put(pg(0, 13'h108), 32'hA2A2_0002);
    put(pg(0, 13'h100), 32'hA0A0_0000);
    put(pg(0, 13'h10C), 32'hA3A3_0003);
    expect_item(0, pg(0, 13'h100), {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000}, "R2 wide commit");
    put(pg(0, 13'h104), 32'hA1A1_0001);
    idle();

    // R3: memory word, high dword first
    put(20'h80044, 32'h5151_0001);
    expect_item(1, 20'h80040, {64'b0, 32'h5151_0001, 32'h5050_0000}, "R3 memory commit");
    put(20'h80040, 32'h5050_0000);
    idle();

    // R4: switching word drops old partial data
    put(pg(0, 13'h200), 32'hBAD0_0000);
    put(pg(0, 13'h204), 32'hBAD0_0001);
    put(pg(0, 13'h300), 32'hC0C0_0000);
    put(pg(0, 13'h208), 32'hB2B2_0002);
    put(pg(0, 13'h20C), 32'hB3B3_0003);
    put(pg(0, 13'h200), 32'hB0B0_0000);
    expect_item(0, pg(0, 13'h200), {32'hB3B3_0003, 32'hB2B2_0002, 32'hB1B1_0001, 32'hB0B0_0000}, "R4 replaced collector");
    put(pg(0, 13'h204), 32'hB1B1_0001);
    idle();

    // R5: full descriptor write, offset A page 5
    put(pg(5, 13'h830), 32'hE0E0_0000);
    put(pg(5, 13'h834), 32'hE1E1_0001);
    put(pg(5, 13'h838), 32'hE2E2_0002);
    expect_item(0, pg(5, 13'h830), {32'hE3E3_0003, 32'hE2E2_0002, 32'hE1E1_0001, 32'hE0E0_0000}, "R5 descriptor full");
    put(pg(5, 13'h83C), 32'hE3E3_0003);
    idle();

    // R6: partial descriptor then top dword
    put(pg(5, 13'h830), 32'hF0F0_0000);
    put(pg(5, 13'h834), 32'hF1F1_0001);
    expect_item(0, pg(5, 13'h830), {32'hF3F3_0003, 96'b0}, "R6 partial zero fill");
    put(pg(5, 13'h83C), 32'hF3F3_0003);
    idle();

    // R7: descriptor low dword discarded while collector busy
    put(pg(0, 13'h100), 32'h7070_0000);
    put(pg(0, 13'h104), 32'h7171_0001);
    put(pg(2, 13'h830), 32'hDEAD_0000);
    put(pg(0, 13'h108), 32'h7272_0002);
    expect_item(0, pg(0, 13'h100), {32'h7373_0003, 32'h7272_0002, 32'h7171_0001, 32'h7070_0000}, "R7 held data intact");
    put(pg(0, 13'h10C), 32'h7373_0003);
    idle();

    // R8: timer command in page 0 empties collector
    put(pg(0, 13'h100), 32'h8080_0000);
    put(pg(0, 13'h104), 32'h8181_0001);
    put(pg(0, 13'h108), 32'h8282_0002);
    expect_item(2, pg(0, 13'h420), {96'b0, 32'h0000_7777}, "R8 timer narrow commit");
    put(pg(0, 13'h420), 32'h0000_7777);
    put(pg(0, 13'h10C), 32'h8383_0003);
    put(pg(0, 13'h100), 32'h8888_0000);
    put(pg(0, 13'h104), 32'h8989_0001);
    expect_item(0, pg(0, 13'h100), {32'h8383_0003, 32'h8A8A_0002, 32'h8989_0001, 32'h8888_0000}, "R8 cleared then refilled");
    put(pg(0, 13'h108), 32'h8A8A_0002);
    idle();

    // R8: timer offset in page 1 keeps collector
    put(pg(0, 13'h100), 32'h9090_0000);
    put(pg(0, 13'h104), 32'h9191_0001);
    put(pg(0, 13'h108), 32'h9292_0002);
    expect_item(2, pg(1, 13'h420), {96'b0, 32'h0000_1111}, "R8 page1 timer narrow");
    put(pg(1, 13'h420), 32'h0000_1111);
    expect_item(0, pg(0, 13'h100), {32'h9393_0003, 32'h9292_0002, 32'h9191_0001, 32'h9090_0000}, "R8 page1 no clear");
    put(pg(0, 13'h10C), 32'h9393_0003);
    idle();

    // R9: narrow write between wide dwords
    put(pg(0, 13'h180), 32'h1010_0000);
    put(pg(0, 13'h184), 32'h1111_0001);
    expect_item(2, pg(4, 13'h400), {96'b0, 32'hCAFE_0400}, "R9 narrow commit");
    put(pg(4, 13'h400), 32'hCAFE_0400);
    put(pg(0, 13'h188), 32'h1212_0002);
    expect_item(0, pg(0, 13'h180), {32'h1313_0003, 32'h1212_0002, 32'h1111_0001, 32'h1010_0000}, "R9 collector untouched");
    put(pg(0, 13'h18C), 32'h1313_0003);
    idle();

    // R10: collector empty after commit; a lone dword must not recommit
    put(pg(0, 13'h1C0), 32'h2020_0000);
    put(pg(0, 13'h1C4), 32'h2121_0001);
    put(pg(0, 13'h1C8), 32'h2222_0002);
    expect_item(0, pg(0, 13'h1C0), {32'h2323_0003, 32'h2222_0002, 32'h2121_0001, 32'h2020_0000}, "R10 first commit");
    put(pg(0, 13'h1CC), 32'h2323_0003);
    put(pg(0, 13'h1CC), 32'h2B2B_0003);
    put(pg(0, 13'h1C0), 32'h2828_0000);
    put(pg(0, 13'h1C4), 32'h2929_0001);
    expect_item(0, pg(0, 13'h1C0), {32'h2B2B_0003, 32'h2A2A_0002, 32'h2929_0001, 32'h2828_0000}, "R10 second commit");
    put(pg(0, 13'h1C8), 32'h2A2A_0002);
    idle();

    // R11: low address bits ignored
    put(pg(0, 13'h241), 32'h3030_0000);
    put(pg(0, 13'h246), 32'h3131_0001);
    put(pg(0, 13'h24B), 32'h3232_0002);
    expect_item(0, pg(0, 13'h240), {32'h3333_0003, 32'h3232_0002, 32'h3131_0001, 32'h3030_0000}, "R11 low bits ignored");
    put(pg(0, 13'h24F), 32'h3333_0003);
    idle();

    check(q_kind.size() == 0, "R10 all expected commits seen", 128'(q_kind.size()), 128'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule